// File: doc/BRIEF.md
# Ingress Frame Release Controller

This block watches one ingress port's Ethernet byte stream and decides when the frame may be handed on toward the switch fabric. Three release policies are available and are chosen per frame:

- **Cut-through** releases once the destination address is in.
- **Fragment-free** waits until a collision fragment can no longer occur.
- **Store-and-forward** waits for the whole frame and its frame check sequence.

While bytes arrive, the block tracks the frame length and runs a CRC-32 over the frame. At the last byte it issues one verdict:

- The frame was good.
- The frame was dropped.
- The frame was defective but had already been released, so it is flagged late.

The block keeps saturating counters of short, oversized and corrupted frames. It stores no payload.

The stream input uses valid/ready. The block never applies back-pressure in normal operation. `in_ready` is low only while reset is asserted. A byte is taken on any rising edge where both `in_valid` and `in_ready` are high. A source may insert idle cycles (valid low) anywhere inside a frame. Those cycles neither count as bytes nor disturb any decision.

Top module: `fwd_gate`

## Requirements
- R1: `in_ready` is 0 while `rst_n` is low and 1 otherwise. A byte is accepted when `in_valid` and `in_ready` are both high. A byte accepted outside a frame without `in_sof` is ignored: it produces no pulse and changes no counter. A byte with `in_sof` always begins a new frame.
- R2: `mode_i` encodes the policy: 0 is cut-through, 1 is fragment-free, and 2 or 3 are store-and-forward. It is sampled only on the byte carrying `in_sof`.
- R3: In cut-through, `fwd_start` pulses for one cycle, in the cycle after the 6th byte is accepted, provided that byte is not the last one.
- R4: In fragment-free, `fwd_start` pulses in the cycle after the 64th byte is accepted, provided that byte is not the last one.
- R5: In store-and-forward, a good frame gives `fwd_start` and `frm_good` together in the cycle after the last byte. A defective frame gives `frm_discard` there, with no `fwd_start`.
- R6: Length counts every byte including the 4 FCS bytes. Fewer than 64 bytes is a runt. More than 1518 bytes is a giant. Frames of exactly 64 and exactly 1518 bytes are valid lengths.
- R7: The FCS check runs a CRC-32 over all bytes, least significant bit first. It uses polynomial 0x04C11DB7 with the register preset to all ones. The frame passes when the final register equals the residue 0xC704DD7B, which is 0xDEBB20E3 in the bit-reversed register. The FCS is sent as the complement of the CRC over the payload, low byte first.
- R8: A frame released before its last byte ends, in the cycle after that byte, with `frm_good` if it is sound or `late_err` if it is defective. It never ends with `frm_discard`.
- R9: In cut-through or fragment-free, a frame whose last byte arrives at or before the release point is judged as in store-and-forward. A frame of exactly 6 bytes in cut-through is therefore a runt and is discarded.
- R10: Each defective frame, in any mode, raises exactly one counter. The counter is chosen in priority order: runt first, then giant, then CRC. The counter updates in the same cycle as the verdict pulse.
- R11: Each counter stops at all ones instead of wrapping.
- R12: A change of `mode_i` after the first byte has no effect on the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock, rising edge |
| rst_n | input | 1 | active-low synchronous reset |
| mode_i | input | 2 | release policy, sampled with start of frame |
| in_valid | input | 1 | a byte is present |
| in_ready | output | 1 | block can accept a byte |
| in_sof | input | 1 | this byte is the first of a frame |
| in_eof | input | 1 | this byte is the last of a frame |
| in_data | input | 8 | frame byte |
| fwd_start | output | 1 | one-cycle release pulse |
| frm_good | output | 1 | frame ended sound |
| frm_discard | output | 1 | frame dropped before release |
| late_err | output | 1 | released frame turned out defective |
| cnt_runt | output | CW | runt frames seen, saturating |
| cnt_giant | output | CW | giant frames seen, saturating |
| cnt_crc | output | CW | CRC-failed frames seen, saturating |

## Verification
The bench targets the boundaries of the release points and of the length classes:

- **Boundary frames.** Frames of 63, 64, 1518 and 1519 bytes are sent, along with a cut-through frame that ends exactly on byte 6. A design with an off-by-one threshold would release or classify one byte early or late.
- **Idle gaps.** A gap inside a frame checks that idle cycles are not counted as bytes.
- **Early release of bad frames.** Bad frames are released early in cut-through. A design that discards after release, or that stays silent, is caught by the late-error check.
- **Mode sampling.** The mode is switched in mid-frame. A design that samples the mode on every byte would release at the wrong point.
- **Counter priority and saturation.** A runt with a bad CRC checks the counter priority. A train of runts drives a small counter past its top, which catches a counter that wraps.

// File: rtl/fwd_pkg.sv
`timescale 1ns/1ps
package fwd_pkg;
  typedef enum logic [1:0] {
    FM_CUT       = 2'd0,
    FM_FRAG      = 2'd1,
    FM_STORE     = 2'd2,
    FM_STORE_ALT = 2'd3
  } fwd_mode_e;

  localparam int ERR_RUNT  = 0;
  localparam int ERR_GIANT = 1;
  localparam int ERR_CRC   = 2;
  localparam int ERR_NUM   = 3;
endpackage

// File: rtl/fcs_crc32.sv
`timescale 1ns/1ps
module fcs_crc32 #(
  parameter logic [31:0] POLY_REFL = 32'hEDB88320,
  parameter logic [31:0] RESIDUE   = 32'hDEBB20E3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       restart,
  input  logic [7:0] data,
  output logic       ok_nxt
);
  logic [31:0] crc_q;
  logic [31:0] crc_nxt;

  // one byte per cycle, least significant bit first, reflected register
  always_comb begin
    crc_nxt = restart ? 32'hFFFF_FFFF : crc_q;
    for (int b = 0; b < 8; b++) begin
      crc_nxt = (crc_nxt[0] ^ data[b]) ? ((crc_nxt >> 1) ^ POLY_REFL) : (crc_nxt >> 1);
    end
  end

  assign ok_nxt = (crc_nxt == RESIDUE);

  always_ff @(posedge clk) begin
    if (!rst_n)  crc_q <= 32'hFFFF_FFFF;
    else if (en) crc_q <= crc_nxt;
  end
endmodule

// File: rtl/len_tracker.sv
`timescale 1ns/1ps
module len_tracker #(
  parameter int MIN_LEN = 64,
  parameter int MAX_LEN = 1518,
  localparam int LW = $clog2(MAX_LEN + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          restart,
  output logic [LW-1:0] len_nxt,
  output logic          runt,
  output logic          giant
);
  localparam logic [LW-1:0] SAT = LW'(MAX_LEN + 1);

  logic [LW-1:0] len_q;

  // length including the byte now on the input; sticks one above the maximum
  always_comb begin
    if (restart)           len_nxt = LW'(1);
    else if (len_q == SAT) len_nxt = len_q;
    else                   len_nxt = len_q + LW'(1);
  end

  assign runt  = len_nxt < LW'(MIN_LEN);
  assign giant = len_nxt > LW'(MAX_LEN);

  always_ff @(posedge clk) begin
    if (!rst_n)  len_q <= '0;
    else if (en) len_q <= len_nxt;
  end
endmodule

// File: rtl/err_counters.sv
`timescale 1ns/1ps
module err_counters #(
  parameter int NUM = 3,
  parameter int CW  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM-1:0]          inc,
  output logic [NUM-1:0][CW-1:0]  cnt
);
  for (genvar i = 0; i < NUM; i++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rst_n)
        cnt[i] <= '0;
      else if (inc[i] && (cnt[i] != {CW{1'b1}}))
        cnt[i] <= cnt[i] + CW'(1);
    end
  end
endmodule

// File: rtl/fwd_gate.sv
`timescale 1ns/1ps
module fwd_gate
  import fwd_pkg::*;
#(
  parameter int CUT_LEN  = 6,
  parameter int FRAG_LEN = 64,
  parameter int MIN_LEN  = 64,
  parameter int MAX_LEN  = 1518,
  parameter int CW       = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode_i,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_sof,
  input  logic          in_eof,
  input  logic [7:0]    in_data,
  output logic          fwd_start,
  output logic          frm_good,
  output logic          frm_discard,
  output logic          late_err,
  output logic [CW-1:0] cnt_runt,
  output logic [CW-1:0] cnt_giant,
  output logic [CW-1:0] cnt_crc
);
  localparam int LW = $clog2(MAX_LEN + 2);

  logic          ready_q, active_q, rel_q;
  fwd_mode_e     mode_q, cur_mode;
  logic          take, was_rel, thr_hit, early, fin, bad;
  logic          crc_ok, runt, giant;
  logic [LW-1:0] len_nxt;
  logic [ERR_NUM-1:0]          err_inc;
  logic [ERR_NUM-1:0][CW-1:0]  err_cnt;

  assign in_ready = ready_q;

  // a byte counts only if it opens a frame or belongs to an open one
  assign take     = in_valid && ready_q && (in_sof || active_q);
  assign cur_mode = in_sof ? fwd_mode_e'(mode_i) : mode_q;
  assign was_rel  = !in_sof && rel_q;

  always_comb begin
    case (cur_mode)
      FM_CUT:  thr_hit = (len_nxt == LW'(CUT_LEN));
      FM_FRAG: thr_hit = (len_nxt == LW'(FRAG_LEN));
      default: thr_hit = 1'b0;
    endcase
  end

  assign early = take && !in_eof && !was_rel && thr_hit;
  assign fin   = take && in_eof;
  assign bad   = runt || giant || !crc_ok;

  assign err_inc[ERR_RUNT]  = fin && runt;
  assign err_inc[ERR_GIANT] = fin && !runt && giant;
  assign err_inc[ERR_CRC]   = fin && !runt && !giant && !crc_ok;

  fcs_crc32 u_crc (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (take),
    .restart (in_sof),
    .data    (in_data),
    .ok_nxt  (crc_ok)
  );

  len_tracker #(.MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)) u_len (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (take),
    .restart (in_sof),
    .len_nxt (len_nxt),
    .runt    (runt),
    .giant   (giant)
  );

  err_counters #(.NUM(ERR_NUM), .CW(CW)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (err_inc),
    .cnt   (err_cnt)
  );

  assign cnt_runt  = err_cnt[ERR_RUNT];
  assign cnt_giant = err_cnt[ERR_GIANT];
  assign cnt_crc   = err_cnt[ERR_CRC];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_q     <= 1'b0;
      active_q    <= 1'b0;
      rel_q       <= 1'b0;
      mode_q      <= FM_CUT;
      fwd_start   <= 1'b0;
      frm_good    <= 1'b0;
      frm_discard <= 1'b0;
      late_err    <= 1'b0;
    end else begin
      ready_q <= 1'b1;
      if (take) begin
        mode_q   <= cur_mode;
        active_q <= !in_eof;
        rel_q    <= !in_eof && (was_rel || early);
      end
      fwd_start   <= early || (fin && !was_rel && !bad);
      frm_good    <= fin && !bad;
      frm_discard <= fin && !was_rel && bad;
      late_err    <= fin && was_rel && bad;
    end
  end
endmodule

// File: rtl/fwd_gate_chk.sv
`timescale 1ns/1ps
module fwd_gate_chk
  import fwd_pkg::*;
#(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          fwd_start,
  input logic          frm_good,
  input logic          frm_discard,
  input logic          late_err,
  input logic [CW-1:0] cnt_runt,
  input logic [CW-1:0] cnt_crc,
  input fwd_mode_e     mode_q
);
  assert_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> in_ready);

  assert_one_verdict_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({frm_good, frm_discard, late_err}));

  assert_no_fwd_on_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frm_discard |-> !fwd_start);

  assert_store_no_early_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_start && !frm_good) |-> (mode_q == FM_CUT || mode_q == FM_FRAG));

  assert_late_only_early_R8: assert property (@(posedge clk) disable iff (!rst_n)
    late_err |-> (mode_q == FM_CUT || mode_q == FM_FRAG));

  assert_runt_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt_runt == $past(cnt_runt) || cnt_runt == CW'($past(cnt_runt) + 1'b1)));

  assert_crc_at_verdict_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_crc != $past(cnt_crc)) |-> (frm_discard || late_err));

  assert_runt_sat_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_runt == {CW{1'b1}}) |=> (cnt_runt == {CW{1'b1}}));
endmodule

bind fwd_gate fwd_gate_chk #(.CW(CW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_ready    (in_ready),
  .fwd_start   (fwd_start),
  .frm_good    (frm_good),
  .frm_discard (frm_discard),
  .late_err    (late_err),
  .cnt_runt    (cnt_runt),
  .cnt_crc     (cnt_crc),
  .mode_q      (mode_q)
);

// File: tb/sim_fwd_gate.sv
`timescale 1ns/1ps
module sim_fwd_gate;
  localparam int CW = 3;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    mode_i = 2'd0;
  logic          in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0]    in_data = 8'h00;
  logic          in_ready, fwd_start, frm_good, frm_discard, late_err;
  logic [CW-1:0] cnt_runt, cnt_giant, cnt_crc;

  always #5 clk = ~clk;

  fwd_gate #(.CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .in_valid(in_valid),
    .in_ready(in_ready), .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
    .fwd_start(fwd_start), .frm_good(frm_good), .frm_discard(frm_discard),
    .late_err(late_err), .cnt_runt(cnt_runt), .cnt_giant(cnt_giant), .cnt_crc(cnt_crc)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // pulse monitor, sampled away from the active edge
  int tot_fwd = 0, tot_good = 0, tot_disc = 0, tot_late = 0, fwd_at = -1;
  always @(negedge clk) if (rst_n) begin
    if (fwd_start)   begin tot_fwd++; fwd_at = cyc; end
    if (frm_good)    tot_good++;
    if (frm_discard) tot_disc++;
    if (late_err)    tot_late++;
  end

  int n_chk = 0, n_fail = 0;
  int m_runt = 0, m_giant = 0, m_crc = 0;
  logic [7:0] fb [0:2047];

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] crc_step(logic [31:0] c, logic [7:0] d);
    logic [31:0] r = c;
    for (int b = 0; b < 8; b++) r = (r[0] ^ d[b]) ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  task automatic build(int len, int seed, bit corrupt);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < len - 4; i++) begin
      fb[i] = 8'(i * 7 + seed);
      c = crc_step(c, fb[i]);
    end
    c = ~c;
    for (int k = 0; k < 4; k++) fb[len - 4 + k] = c[8*k +: 8];
    if (corrupt) fb[3] = fb[3] ^ 8'h01;
  endtask

  // rel: 0 none, 6 after byte 6, 64 after byte 64, 99 after last byte
  // err: 0 none, 1 runt, 2 giant, 3 crc
  task automatic frame_case(string req, int len, logic [1:0] m, logic [1:0] m2, bit corrupt,
                            int gap, int rel, int eg, int ed, int el, int err);
    int b_fwd, b_good, b_disc, b_late, t6, t64, tend, exp_at;
    build(len, len, corrupt);
    b_fwd = tot_fwd; b_good = tot_good; b_disc = tot_disc; b_late = tot_late;
    t6 = -1; t64 = -1; tend = -1;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (i == gap) begin
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1; in_sof = (i == 0); in_eof = (i == len - 1);
      in_data = fb[i]; mode_i = (i == 0) ? m : m2;
      if (i == 5) t6 = cyc;
      if (i == 63) t64 = cyc;
      if (i == len - 1) tend = cyc;
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    repeat (3) @(negedge clk);
    exp_at = (rel == 6) ? t6 + 1 : (rel == 64) ? t64 + 1 : tend + 1;
    chk(req, "fwd_start pulses", tot_fwd - b_fwd, (rel != 0) ? 1 : 0);
    if (rel != 0) chk(req, "fwd_start cycle", fwd_at, exp_at);
    chk(req, "frm_good", tot_good - b_good, eg);
    chk(req, "frm_discard", tot_disc - b_disc, ed);
    chk(req, "late_err", tot_late - b_late, el);
    if (err == 1 && m_runt < CMAX) m_runt++;
    if (err == 2 && m_giant < CMAX) m_giant++;
    if (err == 3 && m_crc < CMAX) m_crc++;
    chk(req, "cnt_runt", int'(cnt_runt), m_runt);
    chk(req, "cnt_giant", int'(cnt_giant), m_giant);
    chk(req, "cnt_crc", int'(cnt_crc), m_crc);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1", "in_ready in reset", int'(in_ready), 0);
    chk("R11", "counters in reset", int'(cnt_runt) + int'(cnt_giant) + int'(cnt_crc), 0);
    chk("R1", "pulses in reset", int'(fwd_start | frm_good | frm_discard | late_err), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "in_ready after reset", int'(in_ready), 1);
  endtask

  task automatic t_stray;
    int b = tot_fwd + tot_good + tot_disc + tot_late;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sof = 1'b0; in_eof = (i == 3); in_data = 8'hA5;
    end
    @(negedge clk); in_valid = 1'b0; in_eof = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "pulses from stray bytes", tot_fwd + tot_good + tot_disc + tot_late - b, 0);
    chk("R1", "counters after stray bytes", int'(cnt_runt) + int'(cnt_giant) + int'(cnt_crc),
        m_runt + m_giant + m_crc);
  endtask

  task automatic t_cut;
    frame_case("R3", 100, 2'd0, 2'd0, 1'b0, -1, 6, 1, 0, 0, 0);
    frame_case("R8_R7", 100, 2'd0, 2'd0, 1'b1, -1, 6, 0, 0, 1, 3);
    frame_case("R8_R6", 1519, 2'd0, 2'd0, 1'b0, -1, 6, 0, 0, 1, 2);
    frame_case("R9", 6, 2'd0, 2'd0, 1'b0, -1, 0, 0, 1, 0, 1);
  endtask

  task automatic t_frag;
    frame_case("R4", 80, 2'd1, 2'd1, 1'b0, 30, 64, 1, 0, 0, 0);
    frame_case("R9_R6", 40, 2'd1, 2'd1, 1'b0, -1, 0, 0, 1, 0, 1);
    frame_case("R9_R4", 64, 2'd1, 2'd1, 1'b0, -1, 99, 1, 0, 0, 0);
  endtask

  task automatic t_store;
    frame_case("R5_R6", 64, 2'd2, 2'd2, 1'b0, -1, 99, 1, 0, 0, 0);
    frame_case("R6", 63, 2'd2, 2'd2, 1'b0, -1, 0, 0, 1, 0, 1);
    frame_case("R6", 1518, 2'd2, 2'd2, 1'b0, -1, 99, 1, 0, 0, 0);
    frame_case("R6", 1519, 2'd2, 2'd2, 1'b0, -1, 0, 0, 1, 0, 2);
    frame_case("R5_R7", 100, 2'd2, 2'd2, 1'b1, 50, 0, 0, 1, 0, 3);
    frame_case("R2", 100, 2'd3, 2'd3, 1'b1, -1, 0, 0, 1, 0, 3);
    frame_case("R10", 40, 2'd2, 2'd2, 1'b1, -1, 0, 0, 1, 0, 1);
  endtask

  task automatic t_mode_hold;
    frame_case("R12", 100, 2'd0, 2'd2, 1'b0, -1, 6, 1, 0, 0, 0);
    frame_case("R12", 100, 2'd2, 2'd0, 1'b0, -1, 99, 1, 0, 0, 0);
  endtask

  task automatic t_saturate;
    for (int k = 0; k < 6; k++) frame_case("R11", 20, 2'd1, 2'd1, 1'b0, -1, 0, 0, 1, 0, 1);
    chk("R11", "runt counter held at top", int'(cnt_runt), CMAX);
  endtask

  initial begin
    t_reset();
    t_stray();
    t_cut();
    t_frag();
    t_store();
    t_mode_hold();
    t_saturate();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule